// File: doc/BRIEF.md
# Guest-mode instruction fault classifier

This block sits beside the instruction decoder of a processor core that supports hardware virtualization. Each decoded instruction comes with the current privilege mode, an instruction class and, for register accesses, a 12-bit control-register address and a write flag. From these, the block decides whether the instruction must trap. When it must, it also decides which of two exception kinds applies. A virtual-instruction fault is raised when a guest tries something that the host supervisor could do on its behalf. An illegal-instruction fault is raised when no mode below machine would be allowed to do it.

The block also takes the three per-counter enable masks and three trap controls as inputs. The enable masks belong to machine level, to the host and to the guest supervisor. The trap controls are a wait-trap bit for all modes below machine, a guest-only wait-trap bit, and a bit that traps address-translation management in the host. Both results are registered. They are valid in the cycle after a decode strobe, and the trap logic of the pipeline consumes them there.

Encodings used throughout are as follows. The mode codes are 0 machine, 1 host supervisor, 2 user, 3 guest supervisor and 4 guest user; codes 5 to 7 act as machine. The instruction class codes are 0 other, 1 register access, 2 hypervisor load/store/fence, 3 wait-for-interrupt, 4 supervisor return and 5 supervisor fence; codes 6 and 7 act as other. For control registers, address bits [9:8] give the lowest privilege level, where 1 is supervisor, 2 is hypervisor/guest-supervisor copies and 3 is machine. Address bits [11:10] = 3 marks a read-only register. Low counters sit at 0xC00 plus the index, and their upper halves sit at 0xC80 plus the index.

Top module: `virt_insn_check`

## Requirements
- R1: After reset both outputs are 0. In the cycle after a clock edge where `dec_valid` is 1, the outputs show the verdict for the inputs sampled at that edge; after an edge where `dec_valid` is 0, both outputs are 0.
- R2: `virt_fault` and `illegal_fault` are never 1 together. When an illegal condition and a virtual condition both hold, only `illegal_fault` is raised.
- R3: In modes 0, 1 and 2, `virt_fault` is always 0. A hypervisor-class instruction (class 2) in mode 2 raises `illegal_fault`, and in modes 0 and 1 it raises no fault.
- R4: In mode 3, a read of low counter 0xC00+i raises `virt_fault` when `ctr_en_m[i]`=1 and `ctr_en_h[i]`=0. It raises nothing when both bits are 1.
- R5: In mode 4, a read of low counter 0xC00+i raises `virt_fault` when `ctr_en_m[i]`=1 and either `ctr_en_h[i]` or `ctr_en_s[i]` is 0.
- R6: Any counter access raises `illegal_fault` in the following cases: `ctr_en_m[i]`=0 in modes 1 to 4; `ctr_en_s[i]`=0 in mode 2; or a write to a counter, since counters are read-only.
- R7: When `xlen32`=1, upper-half counters 0xC80+i follow the same rules with the same bit i. When `xlen32`=0 they raise `illegal_fault`.
- R8: A hypervisor-class instruction (class 2) in modes 3 and 4 raises `virt_fault`.
- R9: In modes 3 and 4, an access to an implemented register with address bits [9:8]=2 (for example 0x600 or 0x680) raises `virt_fault`, whatever the value of `vm_trap`. Accesses to machine-level registers (for example 0x300), to unimplemented addresses (for example 0x7FF) and writes to read-only registers raise `illegal_fault`.
- R10: An access to an implemented supervisor register (for example 0x100) has three outcomes. It raises `virt_fault` in mode 4, no fault in mode 3, and `illegal_fault` in mode 2. In mode 1, an access to 0x180 or 0x680 raises `illegal_fault` when `vm_trap`=1.
- R11: The upper-half registers 0x15D, 0x25D and 0x615 behave like their low partners when `xlen32`=1. When `xlen32`=0 they raise `illegal_fault`.
- R12: Wait-for-interrupt (class 3) behaves as follows in modes 1 to 4. With `wait_trap`=1 it raises `illegal_fault`. With `wait_trap`=0 it raises `virt_fault` in mode 4, and in mode 3 when `guest_wait_trap`=1. In mode 2 it always raises `illegal_fault`. In mode 1 with `wait_trap`=0 it raises nothing.
- R13: Supervisor return (class 4) and supervisor fence (class 5) raise `virt_fault` in mode 4, `illegal_fault` in mode 2 and nothing in mode 3. A supervisor fence in mode 1 raises `illegal_fault` when `vm_trap`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is presented for classification |
| cur_mode | input | 3 | Current privilege mode code |
| xlen32 | input | 1 | 1 when the hart runs with 32-bit registers |
| insn_class | input | 3 | Decoded instruction class code |
| csr_addr | input | 12 | Control-register address for class 1 |
| csr_write | input | 1 | 1 when the register access writes |
| ctr_en_m | input | CTR_N | Machine-level counter enables |
| ctr_en_h | input | CTR_N | Host-level counter enables for guests |
| ctr_en_s | input | CTR_N | Supervisor-level counter enables for user code |
| wait_trap | input | 1 | Trap wait-for-interrupt below machine mode |
| vm_trap | input | 1 | Trap translation management in host supervisor |
| guest_wait_trap | input | 1 | Trap wait-for-interrupt in guest supervisor |
| virt_fault | output | 1 | Registered virtual-instruction verdict |
| illegal_fault | output | 1 | Registered illegal-instruction verdict |

## Verification
This block holds only its two output flags, so any error in the address decode or in mode handling appears at the ports one cycle after the faulting decode strobe. Such an error shows as the wrong fault kind, as both flags at once, or as a missing trap. A mask bit routed to the wrong counter index shows only when that index is accessed with a mix of enable bits. For that reason, the random phase varies all three masks independently and compares every cycle against a behavioural model. A stale register shows as a flag that is still set in the cycle after the strobe drops.

// File: rtl/virt_insn_pkg.sv
// Shared encodings for the guest-mode instruction fault classifier.
// Assumes the mode and class codes are fixed by the surrounding decoder.
package virt_insn_pkg;

    localparam int CSR_ADDR_W = 12;

    typedef enum logic [2:0] {
        MD_MACH    = 3'd0,
        MD_HOST_S  = 3'd1,
        MD_USER    = 3'd2,
        MD_GUEST_S = 3'd3,
        MD_GUEST_U = 3'd4
    } priv_mode_t;

    typedef enum logic [2:0] {
        IC_OTHER     = 3'd0,
        IC_REG       = 3'd1,
        IC_HYP_OP    = 3'd2,
        IC_WAIT      = 3'd3,
        IC_SUP_RET   = 3'd4,
        IC_SUP_FENCE = 3'd5
    } insn_cls_t;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_CTR,
        CK_SUP,
        CK_HYP,
        CK_MACH
    } csr_kind_t;

    typedef struct packed {
        logic ill;
        logic vi;
    } fault_t;

endpackage

// File: rtl/vic_csr_decode.sv
// Classifies a control-register address: counter (with one-hot index),
// supervisor, hypervisor/guest copy, machine, or unimplemented.
// Assumes CTR_N <= 32 so that every index fits address bits [4:0].
module vic_csr_decode
    import virt_insn_pkg::*;
#(
    parameter int CTR_N = 32
) (
    input  logic [CSR_ADDR_W-1:0] addr,
    input  logic                  xlen32,
    output csr_kind_t             kind,
    output logic                  read_only,
    output logic                  xlat_reg,
    output logic [CTR_N-1:0]      ctr_sel
);
    logic ctr_low, ctr_high, ctr_window;
    logic impl_low, impl_high;

    assign ctr_low    = (addr[11:5] == 7'h60);
    assign ctr_high   = (addr[11:5] == 7'h64);
    assign ctr_window = ctr_low | (ctr_high & xlen32);
    assign read_only  = (addr[11:10] == 2'b11);
    assign xlat_reg   = (addr == 12'h180) || (addr == 12'h680);

    // One select line per implemented counter index.
    for (genvar i = 0; i < CTR_N; i++) begin : g_ctr
        assign ctr_sel[i] = ctr_window && (addr[4:0] == 5'(i));
    end

    // Marks the implemented low-half (or full-width) non-counter registers.
    always_comb begin
        case (addr)
            12'h100, 12'h104, 12'h105, 12'h106, 12'h140, 12'h141,
            12'h142, 12'h143, 12'h144, 12'h14D, 12'h180,
            12'h200, 12'h204, 12'h205, 12'h240, 12'h241, 12'h242,
            12'h243, 12'h244, 12'h24D, 12'h280,
            12'h300, 12'h301, 12'h306, 12'h340,
            12'h600, 12'h602, 12'h603, 12'h604, 12'h605, 12'h606,
            12'h680, 12'hF14: impl_low = 1'b1;
            default:          impl_low = 1'b0;
        endcase
    end

    // Upper halves exist only with 32-bit registers.
    always_comb begin
        case (addr)
            12'h15D, 12'h25D, 12'h615: impl_high = xlen32;
            default:                   impl_high = 1'b0;
        endcase
    end

    // Resolves the register kind from the index match and privilege field.
    always_comb begin
        if (|ctr_sel) begin
            kind = CK_CTR;
        end else if (!(impl_low || impl_high)) begin
            kind = CK_NONE;
        end else begin
            case (addr[9:8])
                2'b01:   kind = CK_SUP;
                2'b10:   kind = CK_HYP;
                2'b11:   kind = CK_MACH;
                default: kind = CK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/vic_counter_perm.sv
// Applies the layered counter-enable masks for one selected counter.
// Assumes ctr_sel is one-hot or zero; write protection is handled above.
module vic_counter_perm
    import virt_insn_pkg::*;
#(
    parameter int CTR_N = 32
) (
    input  priv_mode_t       mode,
    input  logic [CTR_N-1:0] ctr_sel,
    input  logic [CTR_N-1:0] en_m,
    input  logic [CTR_N-1:0] en_h,
    input  logic [CTR_N-1:0] en_s,
    output fault_t           verdict
);
    logic m_ok, h_ok, s_ok;

    assign m_ok = |(ctr_sel & en_m);
    assign h_ok = |(ctr_sel & en_h);
    assign s_ok = |(ctr_sel & en_s);

    // Machine mask gates illegal; host and supervisor masks gate guest traps.
    always_comb begin
        verdict = '0;
        case (mode)
            MD_HOST_S:  verdict.ill = !m_ok;
            MD_USER:    verdict.ill = !m_ok || !s_ok;
            MD_GUEST_S: begin
                verdict.ill = !m_ok;
                verdict.vi  = m_ok && !h_ok;
            end
            MD_GUEST_U: begin
                verdict.ill = !m_ok;
                verdict.vi  = m_ok && (!h_ok || !s_ok);
            end
            default:    verdict = '0;
        endcase
    end

endmodule

// File: rtl/vic_insn_perm.sv
// Verdict for the non-register instruction classes (hypervisor ops,
// wait-for-interrupt, supervisor return and fence).
// Assumes the wait timeout is handled elsewhere: a wait trap is immediate.
module vic_insn_perm
    import virt_insn_pkg::*;
(
    input  priv_mode_t mode,
    input  insn_cls_t  cls,
    input  logic       wait_trap,
    input  logic       vm_trap,
    input  logic       guest_wait_trap,
    output fault_t     verdict
);
    // Per-class decision table over the privilege modes.
    always_comb begin
        verdict = '0;
        case (cls)
            IC_HYP_OP: begin
                verdict.ill = (mode == MD_USER);
                verdict.vi  = (mode == MD_GUEST_S) || (mode == MD_GUEST_U);
            end
            IC_WAIT: begin
                if (mode != MD_MACH && wait_trap) begin
                    verdict.ill = 1'b1;
                end else begin
                    verdict.ill = (mode == MD_USER);
                    verdict.vi  = (mode == MD_GUEST_U) ||
                                  (mode == MD_GUEST_S && guest_wait_trap);
                end
            end
            IC_SUP_RET: begin
                verdict.ill = (mode == MD_USER);
                verdict.vi  = (mode == MD_GUEST_U);
            end
            IC_SUP_FENCE: begin
                verdict.ill = (mode == MD_USER) || (mode == MD_HOST_S && vm_trap);
                verdict.vi  = (mode == MD_GUEST_U);
            end
            default: verdict = '0;
        endcase
    end

endmodule

// File: rtl/virt_insn_check.sv
// Top: decides per decoded instruction between no fault, a virtual-
// instruction fault and an illegal-instruction fault, registered one cycle
// after the decode strobe. Illegal wins over virtual.
// Assumes inputs are stable around the sampling edge; reset is synchronous.
module virt_insn_check
    import virt_insn_pkg::*;
#(
    parameter int CTR_N = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_valid,
    input  logic [2:0]            cur_mode,
    input  logic                  xlen32,
    input  logic [2:0]            insn_class,
    input  logic [CSR_ADDR_W-1:0] csr_addr,
    input  logic                  csr_write,
    input  logic [CTR_N-1:0]      ctr_en_m,
    input  logic [CTR_N-1:0]      ctr_en_h,
    input  logic [CTR_N-1:0]      ctr_en_s,
    input  logic                  wait_trap,
    input  logic                  vm_trap,
    input  logic                  guest_wait_trap,
    output logic                  virt_fault,
    output logic                  illegal_fault
);
    priv_mode_t       mode;
    insn_cls_t        cls;
    csr_kind_t        kind;
    logic             read_only, xlat_reg, ro_wr;
    logic [CTR_N-1:0] ctr_sel;
    fault_t           ctr_v, insn_v, reg_v, pick_v;

    assign mode  = (cur_mode > 3'd4) ? MD_MACH : priv_mode_t'(cur_mode);
    assign cls   = (insn_class > 3'd5) ? IC_OTHER : insn_cls_t'(insn_class);
    assign ro_wr = read_only && csr_write;

    vic_csr_decode #(.CTR_N(CTR_N)) u_dec (
        .addr      (csr_addr),
        .xlen32    (xlen32),
        .kind      (kind),
        .read_only (read_only),
        .xlat_reg  (xlat_reg),
        .ctr_sel   (ctr_sel)
    );

    vic_counter_perm #(.CTR_N(CTR_N)) u_ctr (
        .mode    (mode),
        .ctr_sel (ctr_sel),
        .en_m    (ctr_en_m),
        .en_h    (ctr_en_h),
        .en_s    (ctr_en_s),
        .verdict (ctr_v)
    );

    vic_insn_perm u_ins (
        .mode            (mode),
        .cls             (cls),
        .wait_trap       (wait_trap),
        .vm_trap         (vm_trap),
        .guest_wait_trap (guest_wait_trap),
        .verdict         (insn_v)
    );

    // Register-access verdict by mode and register kind.
    always_comb begin
        reg_v = '0;
        case (mode)
            MD_HOST_S: reg_v.ill = (kind inside {CK_NONE, CK_MACH}) || ro_wr ||
                                   (kind == CK_CTR && ctr_v.ill) ||
                                   (xlat_reg && vm_trap);
            MD_USER:   reg_v.ill = (kind != CK_CTR) || ro_wr || ctr_v.ill;
            MD_GUEST_S: begin
                reg_v.ill = (kind inside {CK_NONE, CK_MACH}) || ro_wr ||
                            (kind == CK_CTR && ctr_v.ill);
                reg_v.vi  = (kind == CK_HYP) || (kind == CK_CTR && ctr_v.vi);
            end
            MD_GUEST_U: begin
                reg_v.ill = (kind inside {CK_NONE, CK_MACH}) || ro_wr ||
                            (kind == CK_CTR && ctr_v.ill);
                reg_v.vi  = (kind inside {CK_SUP, CK_HYP}) ||
                            (kind == CK_CTR && ctr_v.vi);
            end
            default:   reg_v.ill = (kind == CK_NONE) || ro_wr;
        endcase
    end

    // Select the verdict source and let illegal suppress virtual.
    always_comb begin
        pick_v    = (cls == IC_REG) ? reg_v : insn_v;
        pick_v.vi = pick_v.vi && !pick_v.ill;
    end

    // Output register, cleared on reset and when no instruction is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            virt_fault    <= 1'b0;
            illegal_fault <= 1'b0;
        end else begin
            virt_fault    <= dec_valid && pick_v.vi;
            illegal_fault <= dec_valid && pick_v.ill;
        end
    end

endmodule

// File: rtl/virt_insn_check_sva.sv
// Property checker for virt_insn_check, attached by bind.
// Assumes it observes the top-level ports only.
module virt_insn_check_sva #(
    parameter int CTR_N = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic [2:0]       cur_mode,
    input logic [2:0]       insn_class,
    input logic [11:0]      csr_addr,
    input logic             wait_trap,
    input logic [CTR_N-1:0] ctr_en_m,
    input logic             virt_fault,
    input logic             illegal_fault
);
    logic [CTR_N-1:0] m_shift;
    logic             low_ctr_hit;

    assign m_shift     = ctr_en_m >> csr_addr[4:0];
    assign low_ctr_hit = (csr_addr[11:5] == 7'h60) && (int'(csr_addr[4:0]) < CTR_N);

    // R2: the two verdicts never coexist
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(virt_fault && illegal_fault));

    // R1: no strobe, no verdict
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !virt_fault && !illegal_fault);

    // R3: non-guest modes never give a virtual verdict
    p_nonguest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (cur_mode <= 3'd2) |=> !virt_fault);

    // R8: hypervisor ops from a guest are virtual faults
    p_hypop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && (cur_mode == 3'd3 || cur_mode == 3'd4) && insn_class == 3'd2
        |=> virt_fault);

    // R6: machine mask clear on a low counter from below machine is illegal
    p_mmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && insn_class == 3'd1 && low_ctr_hit && !m_shift[0] &&
        cur_mode >= 3'd1 && cur_mode <= 3'd4 |=> illegal_fault && !virt_fault);

    // R12: guest-user wait without the global trap is a virtual fault
    p_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && cur_mode == 3'd4 && insn_class == 3'd3 && !wait_trap
        |=> virt_fault);

endmodule

bind virt_insn_check virt_insn_check_sva #(.CTR_N(CTR_N)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .dec_valid     (dec_valid),
    .cur_mode      (cur_mode),
    .insn_class    (insn_class),
    .csr_addr      (csr_addr),
    .wait_trap     (wait_trap),
    .ctr_en_m      (ctr_en_m),
    .virt_fault    (virt_fault),
    .illegal_fault (illegal_fault)
);

// File: tb/virt_insn_check_test.sv
module virt_insn_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [2:0]  cur_mode = '0;
    logic        xlen32 = 1'b0;
    logic [2:0]  insn_class = '0;
    logic [11:0] csr_addr = '0;
    logic        csr_write = 1'b0;
    logic [31:0] ctr_en_m = '1, ctr_en_h = '1, ctr_en_s = '1;
    logic        wait_trap = 1'b0, vm_trap = 1'b0, guest_wait_trap = 1'b0;
    logic        virt_fault, illegal_fault;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    virt_insn_check #(.CTR_N(32)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .cur_mode(cur_mode),
        .xlen32(xlen32), .insn_class(insn_class), .csr_addr(csr_addr),
        .csr_write(csr_write), .ctr_en_m(ctr_en_m), .ctr_en_h(ctr_en_h),
        .ctr_en_s(ctr_en_s), .wait_trap(wait_trap), .vm_trap(vm_trap),
        .guest_wait_trap(guest_wait_trap), .virt_fault(virt_fault),
        .illegal_fault(illegal_fault)
    );

    function automatic bit known_reg(int a, bit xl);
        case (a)
            'h100, 'h104, 'h105, 'h106, 'h140, 'h141, 'h142, 'h143, 'h144,
            'h14D, 'h180, 'h200, 'h204, 'h205, 'h240, 'h241, 'h242, 'h243,
            'h244, 'h24D, 'h280, 'h300, 'h301, 'h306, 'h340, 'h600, 'h602,
            'h603, 'h604, 'h605, 'h606, 'h680, 'hF14: return 1'b1;
            'h15D, 'h25D, 'h615: return xl;
            default: return 1'b0;
        endcase
    endfunction

    // Behavioural reference written from the requirements.
    function automatic void model(input int md, input int cls, input int a,
                                  input bit wr, input bit xl,
                                  input logic [31:0] me, input logic [31:0] he,
                                  input logic [31:0] se, input bit tw,
                                  input bit tvm, input bit vtw,
                                  output bit vi, output bit ii);
        int  lvl;
        int  k;
        bit  ro, is_ctr, known;
        vi = 0; ii = 0;
        if (md > 4) md = 0;
        if (cls == 1) begin
            lvl    = (a >> 8) & 3;
            k      = a & 31;
            ro     = ((a >> 10) & 3) == 3;
            is_ctr = (a >= 'hC00 && a <= 'hC1F) || (xl && a >= 'hC80 && a <= 'hC9F);
            known  = is_ctr || known_reg(a, xl);
            if (!known || (ro && wr) || (md != 0 && lvl == 3)) ii = 1;
            else if (is_ctr) begin
                if (md == 1) ii = !me[k];
                else if (md == 2) ii = !me[k] || !se[k];
                else if (md == 3) begin if (!me[k]) ii = 1; else vi = !he[k]; end
                else if (md == 4) begin if (!me[k]) ii = 1; else vi = !he[k] || !se[k]; end
            end else begin
                if (md == 1) ii = tvm && (a == 'h180 || a == 'h680);
                else if (md == 2) ii = 1;
                else if (md == 3) vi = (lvl == 2);
                else if (md == 4) vi = 1;
            end
        end else if (cls == 2) begin
            if (md == 2) ii = 1; else if (md >= 3) vi = 1;
        end else if (cls == 3) begin
            if (md != 0 && tw) ii = 1;
            else if (md == 2) ii = 1;
            else if (md == 3) vi = vtw;
            else if (md == 4) vi = 1;
        end else if (cls == 4) begin
            if (md == 2) ii = 1; else if (md == 4) vi = 1;
        end else if (cls == 5) begin
            if (md == 2 || (md == 1 && tvm)) ii = 1; else if (md == 4) vi = 1;
        end
    endfunction

    task automatic compare(input string req, input bit ev, input bit ei);
        compared++;
        if (virt_fault !== ev || illegal_fault !== ei) begin
            mismatched++;
            $display("FAIL %s: actual vi=%0b ii=%0b expected vi=%0b ii=%0b (mode=%0d cls=%0d addr=%h)",
                     req, virt_fault, illegal_fault, ev, ei, cur_mode, insn_class, csr_addr);
        end
    endtask

    // Apply one instruction at the current falling edge, check one cycle later.
    task automatic op(input int md, input int cls, input int a, input bit wr,
                      input string req, input bit ev, input bit ei);
        dec_valid  = 1'b1;
        cur_mode   = 3'(md);
        insn_class = 3'(cls);
        csr_addr   = 12'(a);
        csr_write  = wr;
        @(posedge clk);
        @(negedge clk);
        compare(req, ev, ei);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ev, ei;
        // R1: reset state with a faulting instruction presented
        dec_valid = 1'b1; cur_mode = 3'd3; insn_class = 3'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;

        op(0, 2, 0, 0, "R3 machine hyp op", 0, 0);
        op(1, 2, 0, 0, "R3 host hyp op", 0, 0);
        op(2, 2, 0, 0, "R3 user hyp op", 0, 1);
        op(3, 2, 0, 0, "R8 guest-s hyp op", 1, 0);
        op(4, 2, 0, 0, "R8 guest-u hyp op", 1, 0);

        ctr_en_h = 32'hFFFF_FFFD;
        op(3, 1, 'hC01, 0, "R4 guest-s counter host bit 0", 1, 0);
        op(3, 1, 'hC02, 0, "R4 guest-s counter enabled", 0, 0);
        ctr_en_h = '1; ctr_en_s = 32'hFFFF_FFFB;
        op(4, 1, 'hC02, 0, "R5 guest-u counter sup bit 0", 1, 0);
        op(3, 1, 'hC02, 0, "R5 guest-s ignores sup bit", 0, 0);
        op(2, 1, 'hC02, 0, "R6 user counter sup bit 0", 0, 1);
        ctr_en_s = '1;
        op(4, 1, 'hC03, 0, "R5 guest-u counter enabled", 0, 0);

        ctr_en_m = 32'hFFFF_FFFE; ctr_en_h = 32'hFFFF_FFFE;
        op(3, 1, 'hC00, 0, "R6 machine bit 0 beats host bit (R2)", 0, 1);
        op(1, 1, 'hC00, 0, "R6 host machine bit 0", 0, 1);
        op(0, 1, 'hC00, 0, "R6 machine mode ignores masks", 0, 0);
        ctr_en_m = '1; ctr_en_h = '1;
        op(3, 1, 'hC00, 1, "R6 counter write", 0, 1);

        xlen32 = 1'b1; ctr_en_h = 32'hFFFF_FFFD;
        op(3, 1, 'hC81, 0, "R7 upper counter host bit 0", 1, 0);
        xlen32 = 1'b0;
        op(3, 1, 'hC81, 0, "R7 upper counter on 64-bit", 0, 1);
        ctr_en_h = '1;

        op(3, 1, 'h600, 0, "R9 guest-s hyp reg", 1, 0);
        vm_trap = 1'b1;
        op(4, 1, 'h680, 1, "R9 guest-u xlat reg with vm trap", 1, 0);
        op(1, 1, 'h180, 0, "R10 host xlat reg with vm trap", 0, 1);
        vm_trap = 1'b0;
        op(1, 1, 'h180, 0, "R10 host xlat reg no trap", 0, 0);
        op(3, 1, 'h300, 0, "R9 guest machine reg", 0, 1);
        op(4, 1, 'h7FF, 0, "R9 unimplemented", 0, 1);
        op(3, 1, 'hF14, 1, "R9 read-only write", 0, 1);
        op(4, 1, 'h100, 0, "R10 guest-u sup reg", 1, 0);
        op(3, 1, 'h100, 1, "R10 guest-s sup reg", 0, 0);
        op(2, 1, 'h100, 0, "R10 user sup reg", 0, 1);

        xlen32 = 1'b1;
        op(4, 1, 'h15D, 0, "R11 guest-u upper sup reg", 1, 0);
        op(3, 1, 'h615, 0, "R11 guest-s upper hyp reg", 1, 0);
        xlen32 = 1'b0;
        op(4, 1, 'h15D, 0, "R11 upper reg on 64-bit", 0, 1);

        op(4, 3, 0, 0, "R12 guest-u wait", 1, 0);
        op(3, 3, 0, 0, "R12 guest-s wait no trap", 0, 0);
        op(1, 3, 0, 0, "R12 host wait", 0, 0);
        op(2, 3, 0, 0, "R12 user wait", 0, 1);
        guest_wait_trap = 1'b1;
        op(3, 3, 0, 0, "R12 guest-s wait guest trap", 1, 0);
        wait_trap = 1'b1;
        op(3, 3, 0, 0, "R12 wait global trap", 0, 1);
        op(0, 3, 0, 0, "R12 machine wait", 0, 0);
        wait_trap = 1'b0; guest_wait_trap = 1'b0;

        op(4, 4, 0, 0, "R13 guest-u return", 1, 0);
        op(3, 4, 0, 0, "R13 guest-s return", 0, 0);
        op(4, 5, 0, 0, "R13 guest-u fence", 1, 0);
        vm_trap = 1'b1;
        op(1, 5, 0, 0, "R13 host fence vm trap", 0, 1);
        vm_trap = 1'b0;

        // R1: strobe drops after a faulting instruction
        op(4, 2, 0, 0, "R1 fault before idle", 1, 0);
        dec_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare("R1 idle clears", 0, 0);

        // Random phase: model compared on every clock (R2..R13 mixed)
        for (int n = 0; n < 4000; n++) begin
            int sel;
            bit v;
            v          = ($urandom % 8) != 0;
            cur_mode   = 3'($urandom % 8);
            insn_class = 3'($urandom % 8);
            csr_write  = ($urandom % 4) == 0;
            xlen32     = $urandom % 2;
            ctr_en_m   = $urandom | $urandom;
            ctr_en_h   = $urandom | $urandom;
            ctr_en_s   = $urandom | $urandom;
            wait_trap  = ($urandom % 4) == 0;
            vm_trap    = $urandom % 2;
            guest_wait_trap = $urandom % 2;
            sel = $urandom % 4;
            case (sel)
                0: csr_addr = 12'h C00 + 12'($urandom % 32);
                1: csr_addr = 12'h C80 + 12'($urandom % 32);
                2: begin
                    case ($urandom % 8)
                        0: csr_addr = 12'h100; 1: csr_addr = 12'h180;
                        2: csr_addr = 12'h600; 3: csr_addr = 12'h680;
                        4: csr_addr = 12'h15D; 5: csr_addr = 12'h25D;
                        6: csr_addr = 12'h615; default: csr_addr = 12'hF14;
                    endcase
                end
                default: csr_addr = 12'($urandom);
            endcase
            dec_valid = v;
            model(int'(cur_mode), int'(insn_class), int'(csr_addr), csr_write,
                  xlen32, ctr_en_m, ctr_en_h, ctr_en_s, wait_trap, vm_trap,
                  guest_wait_trap, ev, ei);
            if (!v) begin ev = 0; ei = 0; end
            @(posedge clk);
            @(negedge clk);
            compare("R2-model random", ev, ei);
        end

        finish_run();
    end

endmodule